// File: doc/BRIEF.md
# Aligned Transfer Length Splitter

This block breaks one memory segment, given as a base address and a byte count, into a stream of smaller pieces. Each piece fits the per-transfer count limit of a downstream channel and leaves the next piece's address on a 4-byte boundary. A long segment is not cut greedily into maximum-size pieces. The splitter works out how many pieces the remaining length needs, divides that length evenly between them and rounds the share down to a multiple of 4. It repeats this after every piece, so no small fragment is left at the end.

A request enters on a valid/ready handshake and is taken only while the splitter is idle. A request with a misaligned base address or a zero length is taken and then dropped: it raises a one-cycle error pulse and produces no pieces. Pieces leave on a valid/ready stream carrying the address, the length and a last flag. Both divisions use a single shared restoring divider that produces one quotient bit per cycle. While the splitter is working on a segment, a busy output is high.

Top module: `aligned_splitter`

## Requirements
- R1: `in_ready` is high only while the splitter is idle with no piece pending. A request is taken on a cycle where `in_valid` and `in_ready` are both high. While `busy` is high, `in_ready` is low.
- R2: A request whose address has bit 0 or bit 1 set is taken and dropped. `err` is high for exactly the one cycle after the handshake, no piece is emitted and `busy` stays low.
- R3: A request with length zero is dropped in the same way: a one-cycle `err` pulse and no pieces.
- R4: When the remaining length is at most 0x1FFF, the whole remaining length is emitted as one piece with `out_last` = 1, even if it is not a multiple of 4.
- R5: When the remaining length is above 0x1FFF, the piece length is floor(rem / ceil(rem / 0x1FFC)) with its two low bits cleared. It is computed again from the new remaining length after every piece.
- R6: The first piece starts at the base address. Each later piece starts at the previous address plus the previous length. The piece lengths add up to the request length.
- R7: `out_last` is 1 on the piece that brings the remaining length to zero, and 0 on every other piece.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_len` and `out_last` keep their values.
- R9: `busy` is high from the cycle after a good request is taken until the handshake of its last piece. The gap from taking the request, or from a piece handshake, to the next `out_valid` is at most 2*LEN_W+4 cycles.
- R10: Every emitted piece has a length from 1 to 0x1FFF and an address with bits 1:0 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Segment request valid |
| in_ready | output | 1 | Splitter idle and able to take a request |
| in_addr | input | ADDR_W | Segment base address |
| in_len | input | LEN_W | Segment length in bytes |
| out_valid | output | 1 | Piece valid |
| out_ready | input | 1 | Consumer takes the piece |
| out_addr | output | ADDR_W | Piece start address |
| out_len | output | PIECE_W | Piece length in bytes |
| out_last | output | 1 | Piece ends the segment |
| err | output | 1 | One-cycle pulse: request dropped for misalignment or zero length |
| busy | output | 1 | Segment in progress |

## Verification
Faults in the remaining-length register or the address accumulator show up on the very next piece. They appear as a wrong `out_addr` or `out_len`, or as `out_last` firing too early or too late, and the bench compares every piece of every segment against a model of the even-share rule. A divider that stalls or runs short shows up as an `out_valid` gap longer than the per-piece bound, or as a share that is off by one step. A control fault that accepts requests at the wrong time shows up as `in_ready` being high while `busy` is high, or as an error pulse that does not last exactly one cycle.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_COUNT,
        ST_SHARE,
        ST_EMIT
    } split_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] len;
    } seg_t;

    // Largest count representable in a piece of the given width.
    function automatic logic [31:0] piece_max(input int piece_w);
        return (32'd1 << piece_w) - 32'd1;
    endfunction

    // Clear the low alignment bits.
    function automatic logic [31:0] align_down(input logic [31:0] v, input int bits);
        return v & ~((32'd1 << bits) - 32'd1);
    endfunction

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]   acc;
    logic [W-1:0] quo;
    logic [W-1:0] dvs;
    logic [CW-1:0] cnt;
    logic         run;
    logic [W:0]   shifted;
    logic         ge;

    always_comb begin
        shifted = {acc[W-1:0], quo[W-1]};
        ge      = shifted >= {1'b0, dvs};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            quo <= '0;
            dvs <= '0;
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            acc <= '0;
            quo <= dividend;
            dvs <= divisor;
            cnt <= CW'(W);
            run <= 1'b1;
        end else if (run) begin
            if (cnt != '0) begin
                acc <= ge ? (shifted - {1'b0, dvs}) : shifted;
                quo <= {quo[W-2:0], ge};
                cnt <= cnt - 1'b1;
            end else begin
                run <= 1'b0;
            end
        end
    end

    assign busy      = run;
    assign done      = run && (cnt == '0);
    assign quotient  = quo;
    assign remainder = acc[W-1:0];

    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> (!run || done)); // R9
    AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
        done |-> (remainder < dvs)); // R5

endmodule

// File: rtl/req_checker.sv
module req_checker #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 20,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              bad_align,
    output logic              bad_len
);
    assign bad_align = |addr[ALIGN_BITS-1:0];
    assign bad_len   = (len == '0);
endmodule

// File: rtl/aligned_splitter.sv
module aligned_splitter
    import splitter_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 20,
    parameter int PIECE_W    = 13,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [PIECE_W-1:0] out_len,
    output logic              out_last,
    output logic              err,
    output logic              busy
);
    localparam logic [31:0] MAX_CNT  = piece_max(PIECE_W);
    localparam logic [31:0] LIMIT    = align_down(MAX_CNT, ALIGN_BITS);
    localparam logic [LEN_W-1:0] MAX_W   = LEN_W'(MAX_CNT);
    localparam logic [LEN_W-1:0] LIMIT_W = LEN_W'(LIMIT);
    localparam logic [LEN_W-1:0] ALIGN_MASK_W = ~LEN_W'((1 << ALIGN_BITS) - 1);
    localparam int BOUND = 2 * LEN_W + 4;
    localparam int WCW   = $clog2(BOUND + 2) + 1;

    split_state_e      state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem;
    logic [LEN_W-1:0]  piece;
    logic              err_q;

    logic              bad_align, bad_len;
    logic              dv_start, dv_busy, dv_done;
    logic [LEN_W-1:0]  dv_divisor, dv_q, dv_r;
    logic [LEN_W-1:0]  mult;
    logic              take;
    logic              piece_go;

    req_checker #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS)
    ) u_check (
        .addr      (in_addr),
        .len       (in_len),
        .bad_align (bad_align),
        .bad_len   (bad_len)
    );

    seq_divider #(.W(LEN_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (dv_start),
        .dividend  (rem),
        .divisor   (dv_divisor),
        .busy      (dv_busy),
        .done      (dv_done),
        .quotient  (dv_q),
        .remainder (dv_r)
    );

    // ceil(rem / LIMIT) from the first division
    assign mult = dv_q + ((dv_r != '0) ? LEN_W'(1) : '0);

    always_comb begin
        dv_start   = 1'b0;
        dv_divisor = LIMIT_W;
        if (state == ST_PLAN && rem > MAX_W) begin
            dv_start   = 1'b1;
            dv_divisor = LIMIT_W;
        end else if (state == ST_COUNT && dv_done) begin
            dv_start   = 1'b1;
            dv_divisor = mult;
        end
    end

    assign take     = in_valid && in_ready;
    assign piece_go = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            rem      <= '0;
            piece    <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        if (bad_align || bad_len) begin
                            err_q <= 1'b1;
                        end else begin
                            cur_addr <= in_addr;
                            rem      <= in_len;
                            state    <= ST_PLAN;
                        end
                    end
                end
                ST_PLAN: begin
                    if (rem <= MAX_W) begin
                        piece <= rem;
                        state <= ST_EMIT;
                    end else begin
                        state <= ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (dv_done) state <= ST_SHARE;
                end
                ST_SHARE: begin
                    if (dv_done) begin
                        piece <= dv_q & ALIGN_MASK_W;
                        state <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (piece_go) begin
                        cur_addr <= cur_addr + ADDR_W'(piece);
                        rem      <= rem - piece;
                        state    <= (piece == rem) ? ST_IDLE : ST_PLAN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign out_valid = (state == ST_EMIT);
    assign out_addr  = cur_addr;
    assign out_len   = piece[PIECE_W-1:0];
    assign out_last  = (piece == rem);
    assign err       = err_q;

    // Cycles spent waiting for the next piece while busy
    logic [WCW-1:0] wait_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy || out_valid) wait_cnt <= '0;
        else                           wait_cnt <= wait_cnt + 1'b1;
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!out_valid && !dv_busy)); // R1
    AST_ERR_NO_WORK: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !out_valid)); // R2
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
            && $stable(out_len) && $stable(out_last))); // R8
    AST_PIECE_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len != '0 && 32'(out_len) <= MAX_CNT
            && out_addr[ALIGN_BITS-1:0] == '0)); // R10
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (piece_go && out_last) |=> (!busy && in_ready)); // R7
    AST_MID_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (piece_go && !out_last) |=> busy); // R7
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(wait_cnt) <= BOUND); // R9

endmodule

// File: tb/aligned_splitter_test.sv
`timescale 1ns/1ps
module aligned_splitter_test;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 20;
    localparam int PIECE_W = 13;
    localparam int GAP_MAX = 2 * LEN_W + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [ADDR_W-1:0] out_addr;
    logic [PIECE_W-1:0] out_len;
    logic out_last;
    logic err;
    logic busy;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    aligned_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PIECE_W(PIECE_W), .ALIGN_BITS(2)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_len(in_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_len(out_len), .out_last(out_last), .err(err), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned ref_piece(input int unsigned r);
        int unsigned m;
        if (r <= 32'h1FFF) return r;
        m = (r + 32'h1FFB) / 32'h1FFC;
        return (r / m) & ~32'd3;
    endfunction

    task automatic test_reset();
        @(negedge clk);
        check(out_valid == 0, "R1", "reset out_valid", out_valid, 0);
        check(busy == 0, "R9", "reset busy", busy, 0);
        check(in_ready == 1, "R1", "reset in_ready", in_ready, 1);
        check(err == 0, "R2", "reset err", err, 0);
    endtask

    task automatic run_segment(input logic [31:0] a, input int unsigned len, input bit stall);
        int unsigned r;
        logic [31:0] ea;
        int unsigned sum;
        @(negedge clk);
        in_addr = a; in_len = LEN_W'(len); in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(busy == 1, "R9", "busy after take", busy, 1);
        check(in_ready == 0, "R1", "in_ready while busy", in_ready, 0);
        check(err == 0, "R2", "no err on good request", err, 0);
        r = len; ea = a; sum = 0;
        while (r > 0) begin
            int unsigned exp_len;
            int waited;
            exp_len = ref_piece(r);
            waited = 0;
            while (!out_valid && waited < 200) begin
                @(negedge clk);
                waited++;
            end
            check(waited <= GAP_MAX, "R9", "piece gap", waited, GAP_MAX);
            if (!out_valid) return;
            if (stall) begin
                logic [31:0] ha;
                logic [PIECE_W-1:0] hl;
                logic hlast;
                ha = out_addr; hl = out_len; hlast = out_last;
                repeat (3) @(negedge clk);
                check(out_valid && out_addr == ha && out_len == hl && out_last == hlast,
                      "R8", "hold under backpressure", {out_addr, 3'b0, out_len}, {ha, 3'b0, hl});
            end
            check(out_addr == ea, "R6", "piece address", out_addr, ea);
            if (r <= 32'h1FFF)
                check(out_len == PIECE_W'(exp_len), "R4", "single piece length", out_len, exp_len);
            else
                check(out_len == PIECE_W'(exp_len), "R5", "share length", out_len, exp_len);
            check(out_last == (exp_len == r), "R7", "last flag", out_last, (exp_len == r));
            check(out_len != 0 && out_addr[1:0] == 2'b00, "R10", "piece range", out_len, exp_len);
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            ea  = ea + exp_len;
            r   = r - exp_len;
            sum = sum + exp_len;
        end
        check(sum == len, "R6", "sum of lengths", sum, len);
        check(!busy && in_ready, "R9", "idle after last piece", busy, 0);
    endtask

    task automatic bad_request(input logic [31:0] a, input int unsigned len, input string req);
        bit seen;
        @(negedge clk);
        in_addr = a; in_len = LEN_W'(len); in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(err == 1, req, "err pulse", err, 1);
        check(busy == 0, req, "no busy on rejected request", busy, 0);
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (out_valid) seen = 1;
        end
        check(!seen, req, "no piece from rejected request", seen, 0);
        check(err == 0, req, "err lasts one cycle", err, 0);
    endtask

    task automatic test_small();
        run_segment(32'h0000_1000, 100, 0);     // R4
        run_segment(32'h0000_2004, 32'h1FFF, 0); // R4 boundary
        run_segment(32'h0000_3008, 1, 0);        // R4 minimum
    endtask

    task automatic test_large();
        run_segment(32'h0001_0000, 32'h2000, 0);  // R5 just over the limit
        run_segment(32'h0002_0000, 32'h4000, 0);  // R5
        run_segment(32'h0003_0000, 32'h5003, 0);  // R5 unaligned tail
        run_segment(32'h1000_0000, 32'hFFFFF, 0); // R5 largest length
    endtask

    task automatic test_backpressure();
        run_segment(32'h0004_0000, 32'h6001, 1);  // R8
    endtask

    task automatic test_rejects();
        bad_request(32'h0000_1001, 64, "R2");
        bad_request(32'h0000_1002, 64, "R2");
        bad_request(32'h0000_1000, 0, "R3");
    endtask

    task automatic finish_up();
        if (finished) return;
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_small();
        test_large();
        test_backpressure();
        test_rejects();
        run_segment(32'h0005_0000, 40, 0);
        finish_up();
    end

endmodule